// File: doc/BRIEF.md
# Increment/Decrement Register-File Execution Unit

This block executes two instructions of an 8-bit accumulator machine: add one to a data-memory byte, or subtract one from it. Each instruction arrives as a 16-bit word with a qualifying valid strobe. The unit decodes the word and forms a 12-bit data address. It reads the byte, applies the +1 or -1 step, and commits the result in a single clock edge. The result goes either to the working register or back to the same memory byte.

The unit holds its own banked data RAM, the working register, a 4-bit bank register and a 5-bit status register. The bank register supplies the upper address bits for banked accesses. Short-form accesses reach a fixed window made of the bottom of bank 0 and the top of the highest bank.

A side port writes RAM bytes. Two load strobes set the working register and the bank register. A combinational read port exposes any RAM byte. Together these let an environment preload state and inspect it after each instruction.

Top module: `incdec_exec_unit`

## Requirements
- R1: An accepted word whose bits [15:10] equal 001010 is an increment: the result is the addressed byte plus one, modulo 256.
- R2: An accepted word whose bits [15:10] equal 000001 is a decrement: the result is the addressed byte minus one, modulo 256.
- R3: With bit 9 of the word clear, the result is written to the working register and the addressed RAM byte keeps its value.
- R4: With bit 9 of the word set, the result is written to the addressed RAM byte and the working register keeps its value.
- R5: With bit 8 clear and register field bits [7:0] below 0x60, the data address is 0x000 plus the field (bank 0).
- R6: With bit 8 clear and the register field at 0x60 or above, the data address is 0xF00 plus the field (top bank).
- R7: With bit 8 set, the data address is the bank register in bits [11:8] and the register field in bits [7:0].
- R8: status_q bit 2 (zero) is set exactly when the 8-bit result is 0x00, and status_q bit 4 (negative) equals result bit 7.
- R9: For increment, status_q bit 0 (carry) is the carry out of bit 7 and bit 1 (half carry) is the carry out of bit 3. For decrement, both bits mean "no borrow", so carry is clear only for 0x00 and half carry is clear only when the low nibble was 0.
- R10: status_q bit 3 (signed overflow) is set only for 0x7F incremented and 0x80 decremented.
- R11: A valid word matching neither pattern changes no register, flag or RAM byte, and raises illegal_op for exactly one cycle.
- R12: A legal word is completed by the clock edge that accepts it: after that edge the results are visible and retire is high for one cycle.
- R13: After synchronous reset, the working register, bank register and status register read zero, and illegal_op and retire are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_valid | input | 1 | Instruction word present this cycle |
| instr | input | 16 | Instruction word |
| mem_wr_en | input | 1 | Side-port RAM write strobe |
| mem_wr_addr | input | 12 | Side-port RAM write address |
| mem_wr_data | input | 8 | Side-port RAM write data |
| mem_rd_addr | input | 12 | Side-port RAM read address |
| mem_rd_data | output | 8 | Combinational RAM byte at mem_rd_addr |
| w_load_en | input | 1 | Load strobe for the working register |
| w_load_data | input | 8 | Working register load value |
| bank_load_en | input | 1 | Load strobe for the bank register |
| bank_load_data | input | 4 | Bank register load value |
| wreg_q | output | 8 | Working register |
| bank_q | output | 4 | Bank register |
| status_q | output | 5 | Flags {negative, overflow, zero, half carry, carry} |
| illegal_op | output | 1 | One-cycle pulse for an unrecognised word |
| retire | output | 1 | One-cycle pulse for a completed legal instruction |

## Verification
The bench builds the unit with its defaults: a 4-bit bank field, a short-form split at 0x60 and the top bank at 15. This gives a full 4 KiB address space, so both halves of the short-form window and a mid-range banked address can all be reached.

At those values every flag boundary can be reached with byte-sized operands:
- the 0xFF and 0x00 wraps;
- the nibble carry and borrow at 0x0F and 0x10;
- the signed limits 0x7F and 0x80.

The split value lets the bench put 0x5F and 0x60 on either side of the bank choice, with decoy bytes at the other bank to expose a wrong mapping.

// File: rtl/incdec_pkg.sv
package incdec_pkg;

    localparam int DATA_W  = 8;
    localparam int INSTR_W = 16;
    localparam int OPC_W   = 6;

    // opcode field patterns, bits [15:10]
    localparam logic [OPC_W-1:0] OPC_STEP_UP   = 6'b001010;
    localparam logic [OPC_W-1:0] OPC_STEP_DOWN = 6'b000001;

    // status bit positions
    localparam int ST_C  = 0;
    localparam int ST_DC = 1;
    localparam int ST_Z  = 2;
    localparam int ST_OV = 3;
    localparam int ST_N  = 4;
    localparam int ST_W  = 5;

    typedef enum logic [1:0] {
        STEP_NONE = 2'd0,
        STEP_UP   = 2'd1,
        STEP_DOWN = 2'd2
    } step_e;

    typedef struct packed {
        step_e             kind;
        logic              to_file;
        logic              banked;
        logic [DATA_W-1:0] reg_sel;
    } decoded_t;

    typedef struct packed {
        logic neg;
        logic ovf;
        logic zero;
        logic half;
        logic carry;
    } flags_t;

    function automatic step_e classify(input logic [OPC_W-1:0] opc);
        if (opc == OPC_STEP_UP)
            return STEP_UP;
        else if (opc == OPC_STEP_DOWN)
            return STEP_DOWN;
        else
            return STEP_NONE;
    endfunction

endpackage

// File: rtl/incdec_decode.sv
module incdec_decode
    import incdec_pkg::*;
(
    input  logic [INSTR_W-1:0] word,
    output decoded_t           dec
);
    localparam int OPC_LSB = INSTR_W - OPC_W;

    always_comb begin
        dec.kind    = classify(word[INSTR_W-1:OPC_LSB]);
        dec.to_file = word[DATA_W+1];
        dec.banked  = word[DATA_W];
        dec.reg_sel = word[DATA_W-1:0];
    end
endmodule

// File: rtl/incdec_addr.sv
module incdec_addr
    import incdec_pkg::*;
#(
    parameter int                BANK_W       = 4,
    parameter logic [DATA_W-1:0] ACCESS_SPLIT = 8'h60,
    parameter logic [BANK_W-1:0] HIGH_BANK    = '1,
    localparam int               ADDR_W       = BANK_W + DATA_W
) (
    input  logic              banked,
    input  logic [DATA_W-1:0] reg_sel,
    input  logic [BANK_W-1:0] bank_sel,
    output logic [ADDR_W-1:0] addr
);
    logic [BANK_W-1:0] short_bank;

    always_comb begin
        short_bank = (reg_sel < ACCESS_SPLIT) ? '0 : HIGH_BANK;
        addr       = banked ? {bank_sel, reg_sel} : {short_bank, reg_sel};
    end
endmodule

// File: rtl/incdec_alu.sv
module incdec_alu
    import incdec_pkg::*;
(
    input  step_e             kind,
    input  logic [DATA_W-1:0] operand,
    output logic [DATA_W-1:0] result,
    output flags_t            flags
);
    localparam int HALF = DATA_W / 2;
    localparam int UP_W = DATA_W - HALF;

    logic [DATA_W-1:0] addend;
    logic [HALF:0]     low_sum;
    logic [UP_W:0]     high_sum;

    always_comb begin
        // decrement is addition of all ones; carries then mean "no borrow"
        addend   = (kind == STEP_DOWN) ? '1 : DATA_W'(1);
        low_sum  = {1'b0, operand[HALF-1:0]} + {1'b0, addend[HALF-1:0]};
        high_sum = {1'b0, operand[DATA_W-1:HALF]} + {1'b0, addend[DATA_W-1:HALF]}
                   + {{UP_W{1'b0}}, low_sum[HALF]};
        result   = {high_sum[UP_W-1:0], low_sum[HALF-1:0]};

        flags.carry = high_sum[UP_W];
        flags.half  = low_sum[HALF];
        flags.zero  = (result == '0);
        flags.neg   = result[DATA_W-1];
        flags.ovf   = (operand[DATA_W-1] == addend[DATA_W-1]) &&
                      (result[DATA_W-1] != operand[DATA_W-1]);
    end
endmodule

// File: rtl/incdec_ram.sv
module incdec_ram
    import incdec_pkg::*;
#(
    parameter  int ADDR_W = 12,
    localparam int DEPTH  = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] exec_addr,
    output logic [DATA_W-1:0] exec_data,
    input  logic [ADDR_W-1:0] peek_addr,
    output logic [DATA_W-1:0] peek_data
);
    logic [DATA_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we)
            cells[waddr] <= wdata;
    end

    assign exec_data = cells[exec_addr];
    assign peek_data = cells[peek_addr];
endmodule

// File: rtl/incdec_exec_unit.sv
module incdec_exec_unit
    import incdec_pkg::*;
#(
    parameter  int                BANK_W       = 4,
    parameter  logic [DATA_W-1:0] ACCESS_SPLIT = 8'h60,
    parameter  logic [BANK_W-1:0] HIGH_BANK    = '1,
    localparam int                ADDR_W       = BANK_W + DATA_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               instr_valid,
    input  logic [INSTR_W-1:0] instr,
    input  logic               mem_wr_en,
    input  logic [ADDR_W-1:0]  mem_wr_addr,
    input  logic [DATA_W-1:0]  mem_wr_data,
    input  logic [ADDR_W-1:0]  mem_rd_addr,
    output logic [DATA_W-1:0]  mem_rd_data,
    input  logic               w_load_en,
    input  logic [DATA_W-1:0]  w_load_data,
    input  logic               bank_load_en,
    input  logic [BANK_W-1:0]  bank_load_data,
    output logic [DATA_W-1:0]  wreg_q,
    output logic [BANK_W-1:0]  bank_q,
    output logic [ST_W-1:0]    status_q,
    output logic               illegal_op,
    output logic               retire
);
    decoded_t          dec;
    logic [ADDR_W-1:0] op_addr;
    logic [DATA_W-1:0] op_data;
    logic [DATA_W-1:0] alu_res;
    flags_t            alu_flags;
    logic              exec_go;
    logic              ram_we;
    logic [ADDR_W-1:0] ram_waddr;
    logic [DATA_W-1:0] ram_wdata;

    incdec_decode u_decode (
        .word (instr),
        .dec  (dec)
    );

    incdec_addr #(
        .BANK_W       (BANK_W),
        .ACCESS_SPLIT (ACCESS_SPLIT),
        .HIGH_BANK    (HIGH_BANK)
    ) u_addr (
        .banked   (dec.banked),
        .reg_sel  (dec.reg_sel),
        .bank_sel (bank_q),
        .addr     (op_addr)
    );

    incdec_alu u_alu (
        .kind    (dec.kind),
        .operand (op_data),
        .result  (alu_res),
        .flags   (alu_flags)
    );

    // an executing instruction takes the write port ahead of the side port
    always_comb begin
        exec_go   = instr_valid && (dec.kind != STEP_NONE);
        ram_we    = (exec_go && dec.to_file) || mem_wr_en;
        ram_waddr = (exec_go && dec.to_file) ? op_addr : mem_wr_addr;
        ram_wdata = (exec_go && dec.to_file) ? alu_res : mem_wr_data;
    end

    incdec_ram #(
        .ADDR_W (ADDR_W)
    ) u_ram (
        .clk       (clk),
        .we        (ram_we),
        .waddr     (ram_waddr),
        .wdata     (ram_wdata),
        .exec_addr (op_addr),
        .exec_data (op_data),
        .peek_addr (mem_rd_addr),
        .peek_data (mem_rd_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            wreg_q     <= '0;
            bank_q     <= '0;
            status_q   <= '0;
            illegal_op <= 1'b0;
            retire     <= 1'b0;
        end else begin
            if (exec_go && !dec.to_file)
                wreg_q <= alu_res;
            else if (w_load_en)
                wreg_q <= w_load_data;
            if (bank_load_en)
                bank_q <= bank_load_data;
            if (exec_go)
                status_q <= alu_flags;
            illegal_op <= instr_valid && (dec.kind == STEP_NONE);
            retire     <= exec_go;
        end
    end
endmodule

// File: rtl/incdec_exec_chk.sv
module incdec_exec_chk (
    input logic        clk,
    input logic        rst,
    input logic        instr_valid,
    input logic [15:0] instr,
    input logic        w_load_en,
    input logic [7:0]  wreg_q,
    input logic [4:0]  status_q,
    input logic        illegal_op,
    input logic        retire
);
    // R11
    illegal_freeze_chk: assert property (@(posedge clk) disable iff (rst)
        illegal_op |-> ($stable(wreg_q) && $stable(status_q)));

    // R11
    illegal_single_chk: assert property (@(posedge clk) disable iff (rst)
        (illegal_op && !instr_valid) |=> !illegal_op);

    // R12
    one_outcome_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({retire, illegal_op}));

    // R8
    wdest_flags_chk: assert property (@(posedge clk) disable iff (rst)
        (retire && !$past(instr[9])) |->
            ((status_q[2] == (wreg_q == 8'h00)) && (status_q[4] == wreg_q[7])));

    // R4
    file_dest_keeps_w_chk: assert property (@(posedge clk) disable iff (rst)
        (retire && $past(instr[9]) && !$past(w_load_en)) |-> $stable(wreg_q));
endmodule

bind incdec_exec_unit incdec_exec_chk i_exec_chk (
    .clk         (clk),
    .rst         (rst),
    .instr_valid (instr_valid),
    .instr       (instr),
    .w_load_en   (w_load_en),
    .wreg_q      (wreg_q),
    .status_q    (status_q),
    .illegal_op  (illegal_op),
    .retire      (retire)
);

// File: tb/test_incdec_exec_unit.sv
module test_incdec_exec_unit;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        instr_valid = 1'b0;
    logic [15:0] instr = '0;
    logic        mem_wr_en = 1'b0;
    logic [11:0] mem_wr_addr = '0;
    logic [7:0]  mem_wr_data = '0;
    logic [11:0] mem_rd_addr = '0;
    logic [7:0]  mem_rd_data;
    logic        w_load_en = 1'b0;
    logic [7:0]  w_load_data = '0;
    logic        bank_load_en = 1'b0;
    logic [3:0]  bank_load_data = '0;
    logic [7:0]  wreg_q;
    logic [3:0]  bank_q;
    logic [4:0]  status_q;
    logic        illegal_op;
    logic        retire;

    always #10 clk = ~clk;

    incdec_exec_unit i_incdec_exec_unit (
        .clk(clk), .rst(rst), .instr_valid(instr_valid), .instr(instr),
        .mem_wr_en(mem_wr_en), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
        .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
        .w_load_en(w_load_en), .w_load_data(w_load_data),
        .bank_load_en(bank_load_en), .bank_load_data(bank_load_data),
        .wreg_q(wreg_q), .bank_q(bank_q), .status_q(status_q),
        .illegal_op(illegal_op), .retire(retire)
    );

    typedef struct {
        logic [7:0]  w;
        logic [4:0]  st;
        logic        ill;
        logic [11:0] addr;
        logic [7:0]  mem;
        string       tag;
    } expect_t;

    expect_t     sb_q[$];
    logic [7:0]  m_mem [4096];
    logic [7:0]  m_w   = '0;
    logic [3:0]  m_bsr = '0;
    logic [4:0]  m_st  = '0;
    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic logic [11:0] model_addr(input logic a, input logic [7:0] f);
        if (a)
            return {m_bsr, f};
        else if (f < 8'h60)
            return {4'h0, f};
        else
            return {4'hF, f};
    endfunction

    task automatic mem_load(input logic [11:0] ad, input logic [7:0] v);
        @(negedge clk);
        mem_wr_en = 1'b1; mem_wr_addr = ad; mem_wr_data = v;
        @(negedge clk);
        mem_wr_en = 1'b0;
        m_mem[ad] = v;
    endtask

    task automatic w_load(input logic [7:0] v);
        @(negedge clk);
        w_load_en = 1'b1; w_load_data = v;
        @(negedge clk);
        w_load_en = 1'b0;
        m_w = v;
    endtask

    task automatic bank_load(input logic [3:0] v);
        @(negedge clk);
        bank_load_en = 1'b1; bank_load_data = v;
        @(negedge clk);
        bank_load_en = 1'b0;
        m_bsr = v;
    endtask

    task automatic peek(input logic [11:0] ad, input logic [7:0] exp, input string tag);
        @(negedge clk);
        mem_rd_addr = ad;
        #1;
        check(mem_rd_data == exp, tag, "untouched byte", int'(mem_rd_data), int'(exp));
    endtask

    // driver: computes the expected outcome from the requirements and queues it
    task automatic issue(input logic [15:0] ins, input string tag);
        expect_t     e;
        logic [11:0] ad;
        logic [7:0]  op, res;
        logic        c, dc, ov;
        ad = model_addr(ins[8], ins[7:0]);
        op = m_mem[ad];
        e.ill = 1'b0;
        if (ins[15:10] == 6'b001010) begin
            res = op + 8'd1; c = (op == 8'hFF); dc = (op[3:0] == 4'hF); ov = (op == 8'h7F);
        end else if (ins[15:10] == 6'b000001) begin
            res = op - 8'd1; c = (op != 8'h00); dc = (op[3:0] != 4'h0); ov = (op == 8'h80);
        end else begin
            e.ill = 1'b1; res = op; c = 1'b0; dc = 1'b0; ov = 1'b0;
        end
        if (!e.ill) begin
            m_st = {res[7], ov, (res == 8'h00), dc, c};
            if (ins[9]) m_mem[ad] = res;
            else        m_w = res;
        end
        e.w = m_w; e.st = m_st; e.addr = ad; e.mem = m_mem[ad]; e.tag = tag;
        sb_q.push_back(e);
        @(negedge clk);
        instr = ins; instr_valid = 1'b1; mem_rd_addr = ad;
        @(negedge clk);
        instr_valid = 1'b0;
        @(negedge clk);
    endtask

    // monitor: one edge after acceptance the outcome must be visible
    always @(posedge clk) begin
        if (instr_valid && !rst) begin
            expect_t e;
            @(negedge clk);
            e = sb_q.pop_front();
            check(wreg_q == e.w, e.tag, "wreg", int'(wreg_q), int'(e.w));
            check(status_q == e.st, e.tag, "status", int'(status_q), int'(e.st));
            check(mem_rd_data == e.mem, e.tag, "memory", int'(mem_rd_data), int'(e.mem));
            check(illegal_op == e.ill, {e.tag, " R11"}, "illegal_op", int'(illegal_op), int'(e.ill));
            check(retire == !e.ill, {e.tag, " R12"}, "retire", int'(retire), int'(!e.ill));
        end
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R13 reset state
        check(wreg_q == 8'h00, "R13", "wreg", int'(wreg_q), 0);
        check(bank_q == 4'h0, "R13", "bank", int'(bank_q), 0);
        check(status_q == 5'h00, "R13", "status", int'(status_q), 0);
        check(!illegal_op && !retire, "R13", "pulses", int'({illegal_op, retire}), 0);

        // R1 R3: increment into W, memory kept
        mem_load(12'h001, 8'h85);
        issue(16'h2801, "R1 R3");
        // R1 R4: increment into file, W kept
        w_load(8'h90);
        issue(16'h2A01, "R1 R4");
        // R2 R4 then R2 R3
        mem_load(12'h001, 8'h85);
        issue(16'h0601, "R2 R4");
        issue(16'h0401, "R2 R3");

        // R5: short form below split goes to bank 0
        mem_load(12'h05F, 8'h10);
        mem_load(12'hF5F, 8'h20);
        issue(16'h2A5F, "R5");
        peek(12'hF5F, 8'h20, "R5");
        // R6: short form at split goes to top bank
        mem_load(12'hF60, 8'h30);
        mem_load(12'h060, 8'h40);
        issue(16'h2A60, "R6");
        peek(12'h060, 8'h40, "R6");
        // R7: banked form
        bank_load(4'h3);
        check(bank_q == 4'h3, "R7", "bank load", int'(bank_q), 3);
        mem_load(12'h3A0, 8'h11);
        mem_load(12'h0A0, 8'h66);
        issue(16'h2BA0, "R7");
        peek(12'h0A0, 8'h66, "R7");
        bank_load(4'h5);
        mem_load(12'h510, 8'h22);
        issue(16'h2910, "R7 R3");

        // R8 zero and negative
        mem_load(12'h002, 8'h01);
        issue(16'h0402, "R8");
        mem_load(12'h003, 8'h7F);
        issue(16'h2803, "R8 R10");
        // R9 carries and borrows
        mem_load(12'h004, 8'hFF);
        issue(16'h2A04, "R9 R8");
        mem_load(12'h005, 8'h0F);
        issue(16'h2A05, "R9");
        mem_load(12'h006, 8'h00);
        issue(16'h0606, "R9");
        mem_load(12'h007, 8'h10);
        issue(16'h0607, "R9");
        // R10 signed overflow on decrement
        mem_load(12'h008, 8'h80);
        issue(16'h0608, "R10");

        // R11 unrecognised words leave everything unchanged
        w_load(8'h55);
        issue(16'hFFFF, "R11");
        issue(16'h2C01, "R11");
        check(illegal_op == 1'b0, "R11", "pulse width", int'(illegal_op), 0);
        peek(12'h001, m_mem[12'h001], "R11");

        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule